// File: doc/BRIEF.md
# Dual-Port Data Translation Buffer

This block caches page translations for data accesses. It has a parameterised number of fully associative entries, 64 by default. It serves two virtual-address lookups in the same cycle on independent ports. For each lookup it returns a hit flag, a physical address, the entry's protection bits and a cacheable flag. The lookup path is purely combinational from the stored entries, so the results for the addresses presented in a cycle are valid within that cycle.

Each entry holds four things:
- a virtual page tag;
- a page frame number;
- protection bits;
- a 2-bit size code that lets one entry cover 1, 8, 64 or 512 contiguous 8KB pages.

New translations arrive on a single fill port. The slot a fill writes is chosen internally. An empty slot is always taken first. Once the buffer is full, a not-last-used pointer steers the fill away from the entry touched most recently. A synchronous clear-all input drops every translation at once.

Top module: `dual_xlate_buf`

## Requirements
- R1: After reset no entry is valid, and every lookup reports a miss with physical address 0, protection 0 and cacheable 0.
- R2: A lookup hits when a valid entry's tag equals the lookup's virtual page number (address bits above bit 12) in all bits the size code does not mask. A hit returns the entry's protection bits. A miss drives hit, physical address, protection and cacheable to 0.
- R3: On a hit, physical address bits 12:0 equal virtual address bits 12:0.
- R4: Size code 0, 1, 2 or 3 removes the lowest 0, 3, 6 or 9 virtual page number bits from the tag compare. A difference in any higher bit gives a miss.
- R5: On a hit, physical address bits 39:13 are the entry's frame number, except that its lowest 3×(size code) bits are taken from the corresponding virtual page number bits.
- R6: The two lookup ports work independently in the same cycle, and each gives its own result.
- R7: The cacheable output is 1 exactly when the port hits and physical address bit 39 is 0.
- R8: A fill becomes visible to lookups from the cycle after the clock edge at which fill enable is sampled. A lookup in the fill cycle itself sees the old contents.
- R9: While any entry is invalid, a fill writes the lowest-numbered invalid entry and never overwrites a valid one.
- R10: When all entries are valid, a fill writes the entry numbered one above the last-used entry, wrapping from the top entry to entry 0. Last-used is updated as follows:
  - a fill makes its victim the last-used entry;
  - otherwise a hit on port 0 sets last-used to that entry;
  - otherwise a hit on port 1 does.
  - A fill takes precedence over hits in the same cycle.
- R11: Clear-all invalidates every entry at the next clock edge. It overrides a fill requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fillEn | input | 1 | Write a new translation this cycle |
| fillVpn | input | VA_W-OFF_W | Virtual page tag of the new entry |
| fillPfn | input | PA_W-OFF_W | Page frame number of the new entry |
| fillProt | input | PROT_W | Protection bits of the new entry |
| fillGh | input | 2 | Size code of the new entry |
| invAll | input | 1 | Invalidate every entry |
| lkVa | input | 2×VA_W | Virtual address per lookup port |
| lkHit | output | 2 | Hit flag per port |
| lkPa | output | 2×PA_W | Physical address per port |
| lkProt | output | 2×PROT_W | Protection bits per port |
| lkCacheable | output | 2 | Cacheable flag per port |

## Verification
The bench builds the buffer with eight entries and keeps the address widths at their defaults. With eight entries the buffer fills after a few writes, so wrap-around of the not-last-used pointer, priority between the two ports, and precedence of a fill over a hit can all be driven directly. Under the default widths, the frame bit that selects cacheability and all four size codes are exercised exactly as they would be in the full-size buffer.

// File: rtl/dxbPkg.sv
package dxbPkg;
  // strobes from the control to the entry storage
  typedef struct packed {
    logic wrEn;    // write the selected victim slot
    logic clrAll;  // drop every valid bit
  } ctrlStrobe_t;

  // low virtual page bits ignored for each size code
  function automatic logic [8:0] ghSpan(input logic [1:0] g);
    case (g)
      2'd0:    ghSpan = 9'h000;
      2'd1:    ghSpan = 9'h007;
      2'd2:    ghSpan = 9'h03F;
      default: ghSpan = 9'h1FF;
    endcase
  endfunction
endpackage

// File: rtl/dxb_datapath.sv
module dxb_datapath
  import dxbPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W = 30,
  parameter int PFN_W = 27,
  parameter int OFF_W = 13,
  parameter int PROT_W = 4,
  parameter int NPORT = 2,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrlStrobe_t                        strobe,
  input  logic [IDX_W-1:0]                   wrIdx,
  input  logic [VPN_W-1:0]                   fillVpn,
  input  logic [PFN_W-1:0]                   fillPfn,
  input  logic [PROT_W-1:0]                  fillProt,
  input  logic [1:0]                         fillGh,
  input  logic [NPORT-1:0][VA_W-1:0]         lkVa,
  output logic [ENTRIES-1:0]                 validVec,
  output logic [NPORT-1:0][ENTRIES-1:0]      hitVec,
  output logic [NPORT-1:0]                   lkHit,
  output logic [NPORT-1:0][PA_W-1:0]         lkPa,
  output logic [NPORT-1:0][PROT_W-1:0]       lkProt,
  output logic [NPORT-1:0]                   lkCacheable
);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   tagQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ  [ENTRIES];
  logic [PROT_W-1:0]  protQ [ENTRIES];
  logic [1:0]         ghQ   [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               validQ <= '0;
    else if (strobe.clrAll)  validQ <= '0;
    else if (strobe.wrEn)    validQ[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagQ[wrIdx]  <= fillVpn;
      pfnQ[wrIdx]  <= fillPfn;
      protQ[wrIdx] <= fillProt;
      ghQ[wrIdx]   <= fillGh;
    end
  end

  assign validVec = validQ;

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (validQ == '0)); // R11
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> validQ[$past(wrIdx)]); // R8

  for (genvar p = 0; p < NPORT; p++) begin : gPort
    logic [VPN_W-1:0]   vpn;
    logic [OFF_W-1:0]   off;
    logic [ENTRIES-1:0] match;
    logic [PFN_W-1:0]   pfnSel;
    logic [PROT_W-1:0]  protSel;

    assign vpn = lkVa[p][VA_W-1:OFF_W];
    assign off = lkVa[p][OFF_W-1:0];

    // tag compare with size masking, frame merge with the virtual bits
    always_comb begin
      match   = '0;
      pfnSel  = '0;
      protSel = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (validQ[i] &&
            (((vpn ^ tagQ[i]) & ~VPN_W'(ghSpan(ghQ[i]))) == '0)) begin
          match[i] = 1'b1;
          pfnSel  |= (pfnQ[i] & ~PFN_W'(ghSpan(ghQ[i])))
                   | PFN_W'(vpn[8:0] & ghSpan(ghQ[i]));
          protSel |= protQ[i];
        end
      end
    end

    assign hitVec[p]      = match;
    assign lkHit[p]       = |match;
    assign lkPa[p]        = (|match) ? {pfnSel, off} : '0;
    assign lkProt[p]      = protSel;
    assign lkCacheable[p] = (|match) & ~pfnSel[PFN_W-1];

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !lkHit[p] |-> (lkPa[p] == '0) && (lkProt[p] == '0) && !lkCacheable[p]); // R2
    AST_CACHE_RULE: assert property (@(posedge clk) disable iff (!rstN)
      lkCacheable[p] |-> lkHit[p] && !lkPa[p][PA_W-1]); // R7
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
      lkHit[p] |-> (lkPa[p][OFF_W-1:0] == lkVa[p][OFF_W-1:0])); // R3
  end

endmodule

// File: rtl/dxb_ctrl.sv
module dxb_ctrl
  import dxbPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int NPORT = 2,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          fillReq,
  input  logic                          invReq,
  input  logic [ENTRIES-1:0]            validVec,
  input  logic [NPORT-1:0][ENTRIES-1:0] hitVec,
  output ctrlStrobe_t                   strobe,
  output logic [IDX_W-1:0]              victim
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]             lastUsed;
  logic [IDX_W-1:0]             firstFree;
  logic [IDX_W-1:0]             nextAfter;
  logic                         anyFree;
  logic [NPORT-1:0][IDX_W-1:0]  hitIdx;
  logic [IDX_W-1:0]             touchIdx;
  logic                         touchVld;

  // lowest-numbered invalid slot
  always_comb begin
    firstFree = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) firstFree = IDX_W'(i);
    end
  end

  // encode the one-hot hit vector of each port
  always_comb begin
    hitIdx = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (hitVec[p][i]) hitIdx[p] = IDX_W'(i);
      end
    end
  end

  // lowest-numbered hitting port wins the last-used update
  always_comb begin
    touchIdx = '0;
    touchVld = 1'b0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (|hitVec[p]) begin
        touchIdx = hitIdx[p];
        touchVld = 1'b1;
      end
    end
  end

  assign anyFree   = ~&validVec;
  assign nextAfter = (lastUsed == TOP_IDX) ? '0 : lastUsed + 1'b1;
  assign victim    = anyFree ? firstFree : nextAfter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lastUsed <= TOP_IDX;
    else if (invReq)   lastUsed <= TOP_IDX;
    else if (fillReq)  lastUsed <= victim;
    else if (touchVld) lastUsed <= touchIdx;
  end

  assign strobe.wrEn   = fillReq & ~invReq;
  assign strobe.clrAll = invReq;

  AST_NLU_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && !invReq && (&validVec) |-> (victim != lastUsed)); // R10
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && !invReq && !(&validVec) |-> !validVec[victim]); // R9
  AST_HIT_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    !fillReq && !invReq && (|hitVec[0]) |=> (lastUsed == $past(hitIdx[0]))); // R10
  AST_FILL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && !invReq |=> (lastUsed == $past(victim))); // R10

endmodule

// File: rtl/dual_xlate_buf.sv
module dual_xlate_buf
  import dxbPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W = 43,
  parameter int PA_W = 40,
  parameter int OFF_W = 13,
  parameter int PROT_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fillEn,
  input  logic [VA_W-OFF_W-1:0]      fillVpn,
  input  logic [PA_W-OFF_W-1:0]      fillPfn,
  input  logic [PROT_W-1:0]          fillProt,
  input  logic [1:0]                 fillGh,
  input  logic                       invAll,
  input  logic [1:0][VA_W-1:0]       lkVa,
  output logic [1:0]                 lkHit,
  output logic [1:0][PA_W-1:0]       lkPa,
  output logic [1:0][PROT_W-1:0]     lkProt,
  output logic [1:0]                 lkCacheable
);

  localparam int NPORT = 2;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  ctrlStrobe_t                  strobe;
  logic [IDX_W-1:0]             victim;
  logic [ENTRIES-1:0]           validVec;
  logic [NPORT-1:0][ENTRIES-1:0] hitVec;

  dxb_ctrl #(.ENTRIES(ENTRIES), .NPORT(NPORT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fillReq  (fillEn),
    .invReq   (invAll),
    .validVec (validVec),
    .hitVec   (hitVec),
    .strobe   (strobe),
    .victim   (victim)
  );

  dxb_datapath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .OFF_W(OFF_W), .PROT_W(PROT_W), .NPORT(NPORT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrIdx       (victim),
    .fillVpn     (fillVpn),
    .fillPfn     (fillPfn),
    .fillProt    (fillProt),
    .fillGh      (fillGh),
    .lkVa        (lkVa),
    .validVec    (validVec),
    .hitVec      (hitVec),
    .lkHit       (lkHit),
    .lkPa        (lkPa),
    .lkProt      (lkProt),
    .lkCacheable (lkCacheable)
  );

endmodule

// File: tb/dual_xlate_buf_tb.sv
module dual_xlate_buf_tb;

  localparam int ENT = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             fillEn;
  logic [29:0]      fillVpn;
  logic [26:0]      fillPfn;
  logic [3:0]       fillProt;
  logic [1:0]       fillGh;
  logic             invAll;
  logic [1:0][42:0] lkVa;
  logic [1:0]       lkHit;
  logic [1:0][39:0] lkPa;
  logic [1:0][3:0]  lkProt;
  logic [1:0]       lkCacheable;

  always #5 clk = ~clk;

  dual_xlate_buf #(.ENTRIES(ENT)) u_dut (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .fillVpn(fillVpn),
    .fillPfn(fillPfn), .fillProt(fillProt), .fillGh(fillGh),
    .invAll(invAll), .lkVa(lkVa), .lkHit(lkHit), .lkPa(lkPa),
    .lkProt(lkProt), .lkCacheable(lkCacheable)
  );

  typedef struct {
    int          port;
    bit          hit;
    logic [39:0] pa;
    logic [3:0]  prot;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [29:0] eVpn  [16];
  logic [26:0] ePfn  [16];
  logic [3:0]  eProt [16];
  int          eGh   [16];

  function automatic logic [42:0] va(int id, logic [12:0] off);
    return {eVpn[id], off};
  endfunction

  // expected physical address from the entry fields (R3, R5)
  function automatic logic [39:0] paFor(int id, logic [42:0] v);
    logic [26:0] m;
    m = 27'((1 << (3 * eGh[id])) - 1);
    return {(ePfn[id] & ~m) | (v[39:13] & m), v[12:0]};
  endfunction

  task automatic expHit(int port, int id, string req);
    exp_t e;
    e.port = port; e.hit = 1'b1; e.pa = paFor(id, lkVa[port]);
    e.prot = eProt[id]; e.req = req;
    q.push_back(e);
  endtask

  task automatic expMiss(int port, string req);
    exp_t e;
    e.port = port; e.hit = 1'b0; e.pa = '0; e.prot = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic setFill(int id, logic [29:0] v, logic [26:0] f,
                         logic [3:0] pr, int gh);
    eVpn[id] = v; ePfn[id] = f; eProt[id] = pr; eGh[id] = gh;
    fillEn = 1'b1; fillVpn = v; fillPfn = f; fillProt = pr;
    fillGh = 2'(gh);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    fillEn = 1'b0;
    invAll = 1'b0;
  endtask

  // monitor: compare every queued expectation mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      automatic exp_t e = q.pop_front();
      automatic bit expC = e.hit && !e.pa[39];
      checks++;
      if (lkHit[e.port] !== e.hit || lkPa[e.port] !== e.pa ||
          lkProt[e.port] !== e.prot || lkCacheable[e.port] !== expC) begin
        errors++;
        $display("FAIL %s port%0d: got hit=%b pa=%h prot=%h cach=%b, expected hit=%b pa=%h prot=%h cach=%b",
                 e.req, e.port, lkHit[e.port], lkPa[e.port], lkProt[e.port],
                 lkCacheable[e.port], e.hit, e.pa, e.prot, expC);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; fillEn = 1'b0; invAll = 1'b0; lkVa = '0;
    fillVpn = '0; fillPfn = '0; fillProt = '0; fillGh = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: empty after reset
    lkVa[0] = '0; lkVa[1] = {30'h0ABC_1230, 13'h0};
    expMiss(0, "R1"); expMiss(1, "R1"); tick();

    // R8: lookup in the fill cycle sees old contents
    setFill(0, 30'h0ABC_1230, 27'h012_3450, 4'h1, 0);
    lkVa[0] = va(0, 13'h1F0); expMiss(0, "R8");
    lkVa[1] = '0;             expMiss(1, "R8");
    tick();
    // R2 R3: hit with offset pass-through on both ports
    lkVa[0] = va(0, 13'h1F0); expHit(0, 0, "R2");
    lkVa[1] = va(0, 13'h0007); expHit(1, 0, "R3");
    tick();
    // R4 size 0 compares every page bit; R6 ports independent
    lkVa[0] = {30'h0ABC_1231, 13'h0}; expMiss(0, "R4");
    lkVa[1] = va(0, 13'h1FFF);        expHit(1, 0, "R6");
    tick();

    // size code 1
    setFill(1, 30'h0111_2228, 27'h555_5550, 4'h6, 1); tick();
    lkVa[0] = {eVpn[1] | 30'h5, 13'h0AA};   expHit(0, 1, "R5");
    lkVa[1] = {eVpn[1] ^ 30'h8, 13'h0AA};   expMiss(1, "R4");
    tick();

    // size code 3, frame bit 39 set: not cacheable
    setFill(2, 30'h0222_0000, 27'h400_0000, 4'h3, 3); tick();
    lkVa[0] = {eVpn[2] | 30'h1FF, 13'h123}; expHit(0, 2, "R7");
    lkVa[1] = {eVpn[2] + 30'h200, 13'h123}; expMiss(1, "R4");
    tick();

    // size code 2
    setFill(3, 30'h0333_3040, 27'h012_33C0, 4'h9, 2); tick();
    lkVa[0] = {eVpn[3] | 30'h2A, 13'h0};    expHit(0, 3, "R5");
    lkVa[1] = {eVpn[3] ^ 30'h40, 13'h0};    expMiss(1, "R4");
    tick();

    for (int k = 0; k < 4; k++) begin
      setFill(4 + k, 30'h1000_0000 + 30'(k * 32'h1000), 27'h010_0000 + 27'(k),
              4'(k), 0);
      tick();
    end

    // R9: every fill landed in a free slot, nothing overwritten
    lkVa[0] = va(0, 13'h0); expHit(0, 0, "R9");
    lkVa[1] = va(1, 13'h0); expHit(1, 1, "R9"); tick();
    lkVa[0] = va(2, 13'h0); expHit(0, 2, "R9");
    lkVa[1] = va(3, 13'h0); expHit(1, 3, "R9"); tick();
    lkVa[0] = va(4, 13'h0); expHit(0, 4, "R9");
    lkVa[1] = va(5, 13'h0); expHit(1, 5, "R9"); tick();
    lkVa[0] = va(6, 13'h0); expHit(0, 6, "R9");
    lkVa[1] = '0;           expMiss(1, "R9"); tick();
    lkVa[0] = '0;           expMiss(0, "R9");
    lkVa[1] = va(7, 13'h0); expHit(1, 7, "R9"); tick();   // last-used = 7

    // R10: full, last-used 7 -> victim wraps to slot 0
    setFill(8, 30'h2000_0001, 27'h020_0001, 4'hA, 0); tick();
    lkVa[0] = va(0, 13'h0); expMiss(0, "R10");
    lkVa[1] = va(8, 13'h0); expHit(1, 8, "R10"); tick();   // last-used 0
    lkVa[0] = '0;           expMiss(0, "R10");
    lkVa[1] = va(3, 13'h0); expHit(1, 3, "R10"); tick();   // port1 hit -> 3
    setFill(9, 30'h2000_0002, 27'h020_0002, 4'hB, 0); tick(); // slot 4
    lkVa[0] = va(4, 13'h0); expMiss(0, "R10");
    lkVa[1] = va(9, 13'h0); expHit(1, 9, "R10"); tick();
    // R6 R10: both ports hit, port 0 sets last-used (slot 1)
    lkVa[0] = va(1, 13'h0); expHit(0, 1, "R6");
    lkVa[1] = va(5, 13'h0); expHit(1, 5, "R6"); tick();
    setFill(10, 30'h2000_0003, 27'h020_0003, 4'hC, 0); tick(); // slot 2
    lkVa[0] = va(2, 13'h0);  expMiss(0, "R10");
    lkVa[1] = va(10, 13'h0); expHit(1, 10, "R10"); tick();  // last-used 2
    // R10: fill beats a same-cycle hit on slot 6; victim slot 3
    setFill(11, 30'h2000_0004, 27'h020_0004, 4'hD, 0);
    lkVa[0] = va(6, 13'h0); expHit(0, 6, "R10");
    lkVa[1] = '0;           expMiss(1, "R10");
    tick();
    setFill(12, 30'h2000_0005, 27'h020_0005, 4'hE, 0); tick(); // slot 4
    lkVa[0] = va(9, 13'h0);  expMiss(0, "R10");
    lkVa[1] = va(7, 13'h0);  expHit(1, 7, "R10"); tick();
    lkVa[0] = va(3, 13'h0);  expMiss(0, "R10");
    lkVa[1] = va(11, 13'h0); expHit(1, 11, "R10"); tick();
    lkVa[0] = va(12, 13'h0); expHit(0, 12, "R10");
    lkVa[1] = va(6, 13'h0);  expHit(1, 6, "R10"); tick();

    // R11: clear-all overrides a same-cycle fill
    setFill(13, 30'h3000_0001, 27'h030_0001, 4'h5, 0);
    invAll = 1'b1;
    lkVa[0] = va(12, 13'h0); expHit(0, 12, "R11");
    lkVa[1] = '0;            expMiss(1, "R11");
    tick();
    lkVa[0] = va(13, 13'h0); expMiss(0, "R11");
    lkVa[1] = va(12, 13'h0); expMiss(1, "R11"); tick();
    lkVa[0] = va(7, 13'h0);  expMiss(0, "R11");
    lkVa[1] = va(8, 13'h0);  expMiss(1, "R11"); tick();

    // refill after clear
    setFill(14, 30'h3000_0002, 27'h030_0002, 4'h7, 1); tick();
    setFill(15, 30'h3000_0010, 27'h030_0010, 4'h2, 0); tick();
    lkVa[0] = va(14, 13'h055); expHit(0, 14, "R9");
    lkVa[1] = va(15, 13'h0AA); expHit(1, 15, "R9"); tick();

    @(negedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule